// File: doc/BRIEF.md
# Synchronous Tag Store with Word Comparator

This block is a single-port synchronous memory that holds cache tags and checks them against a presented word. Address, the three-part chip select, the write strobe and the data-enable are all sampled on the rising clock edge. A separate input register captures the data bus only in cycles where data-enable is active. That register supplies both the write data and the compare operand.

A compare is a selected read cycle with data-enable active. The addressed word is read internally and checked against the registered input word, and a match flag results. Usually the output-enable is held inactive during a compare, so the data bus stays quiet while the tag is loaded. A fill write is a selected write with data-enable inactive. It stores the word still held in the input register and ignores the bus, so a missed tag can be written back without driving it again.

A mode input chooses when results appear. In pipeline mode (mode high) the read data and the match flag each pass through one more output register. In flow-through mode (mode low) they come straight from the array and the comparator. Each tri-state output is modelled as a value plus a drive-enable. The data and match drive-enables follow their asynchronous enable inputs.

Top module: `tag_cam_ram`

## Requirements
- R1: A cycle is selected only when en1_n=0, en2=1 and en3_n=0 at the clock edge. Any other pattern writes nothing, produces no data drive and yields match=1.
- R2: The input register loads din only at edges where den_n=0. At other edges it keeps its value, whatever din is.
- R3: A selected cycle with wr_n=0 and den_n=0 stores din at addr. A later read returns exactly that word.
- R4: A selected cycle with wr_n=0 and den_n=1 (fill write) stores the word already held in the input register at addr. din has no effect.
- R5: A selected cycle with wr_n=1 and den_n=0 is a compare. match=1 only if every one of the WIDTH bits of the stored word equals the registered input word, and match=0 otherwise.
- R6: After any cycle that is not a compare, including a deselected one, match reads 1.
- R7: match_en equals the inverse of moe_n at once, without waiting for a clock. dout_en is 0 whenever oe_n=1, also at once.
- R8: With pipe_mode=0, a cycle's read data, data-drive qualification and match result appear in the clock period that follows its sampling edge.
- R9: With pipe_mode=1, the same results appear one clock period later than in R8.
- R10: dout_en=1 only for a selected cycle with wr_n=1 (a read or a compare) while oe_n=0. Write and deselected cycles never drive dout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control and output registers |
| pipe_mode | input | 1 | 1 = pipeline (registered outputs), 0 = flow-through |
| en1_n | input | 1 | Chip select, active low |
| en2 | input | 1 | Chip select, active high |
| en3_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| den_n | input | 1 | Data-enable for the input register, active low |
| oe_n | input | 1 | Asynchronous data output enable, active low |
| moe_n | input | 1 | Asynchronous match output enable, active low |
| addr | input | AW | Word address |
| din | input | WIDTH | Data input bus |
| dout | output | WIDTH | Data output value |
| dout_en | output | 1 | Data output drive enable |
| match | output | 1 | Match flag value |
| match_en | output | 1 | Match flag drive enable |

## Verification
A command is sampled at edge N. In flow-through mode its data, drive qualification and match flag are due in the period after edge N. In pipeline mode they are due one edge later. The bench drives each command at a falling edge and updates its reference model after the following rising edge. It compares the outputs at the next falling edge against the model's flow-through stage or its one-deep pipeline stage, depending on the current mode. The asynchronous enables are checked a short delay after they change inside a period, with no clock edge in between.

// File: rtl/tag_cam_ram.sv
module tag_cam_ram #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pipe_mode,
  input  logic             en1_n,
  input  logic             en2,
  input  logic             en3_n,
  input  logic             wr_n,
  input  logic             den_n,
  input  logic             oe_n,
  input  logic             moe_n,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             dout_en,
  output logic             match,
  output logic             match_en
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] hold, hold_nx, rdata, dout_p;
  logic [AW-1:0]    a_q;
  logic             sel, rd_q, cmp_q, rd_p, match_p, match_ft;

  assign sel     = !en1_n && en2 && !en3_n;
  assign hold_nx = den_n ? hold : din;

  always_ff @(posedge clk)
    if (sel && !wr_n) mem[addr] <= hold_nx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold    <= '0;
      a_q     <= '0;
      rd_q    <= 1'b0;
      cmp_q   <= 1'b0;
      rd_p    <= 1'b0;
      match_p <= 1'b1;
      dout_p  <= '0;
    end else begin
      hold    <= hold_nx;
      a_q     <= addr;
      rd_q    <= sel && wr_n;
      cmp_q   <= sel && wr_n && !den_n;
      rd_p    <= rd_q;
      match_p <= match_ft;
      dout_p  <= rdata;
    end

  assign rdata    = mem[a_q];
  assign match_ft = !cmp_q || (rdata == hold);

  assign dout     = pipe_mode ? dout_p : rdata;
  assign dout_en  = !oe_n && (pipe_mode ? rd_p : rd_q);
  assign match    = pipe_mode ? match_p : match_ft;
  assign match_en = !moe_n;

endmodule

module tag_cam_ram_chk #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pipe_mode,
  input logic             en1_n,
  input logic             en2,
  input logic             en3_n,
  input logic             wr_n,
  input logic             den_n,
  input logic             oe_n,
  input logic             moe_n,
  input logic [AW-1:0]    addr,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] dout,
  input logic             dout_en,
  input logic             match,
  input logic             match_en
);
  logic picked;
  assign picked = !en1_n && en2 && !en3_n;

  AST_DESEL_MATCH_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && $past(!picked)) |-> match);  // R6
  AST_DESEL_MATCH_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && $past(!picked, 2)) |-> match);  // R9
  AST_OE_BLOCKS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en);  // R7
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && $past(picked && !wr_n)) |-> !dout_en);  // R10
endmodule

bind tag_cam_ram tag_cam_ram_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/test_tag_cam_ram.sv
`timescale 1ns/1ps
module test_tag_cam_ram;
  localparam int W = 18, D = 64, AW = 6;

  logic clk = 0, rst_n = 0, pipe_mode = 0;
  logic en1_n = 1, en2 = 0, en3_n = 1, wr_n = 1, den_n = 1, oe_n = 1, moe_n = 1;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  din = '0;
  logic [W-1:0]  dout;
  logic dout_en, match, match_en;

  always #10 clk = ~clk;

  tag_cam_ram #(.WIDTH(W), .DEPTH(D)) i_tag_cam_ram (.*);

  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [W-1:0]  m_mem [D];
  logic [W-1:0]  m_hold = '0, p_d = '0;
  logic [AW-1:0] f_a = '0;
  bit f_rd = 0, f_cmp = 0, p_rd = 0, p_m = 1;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit c1n, bit c2, bit c3n, bit wrn, bit denn, bit oen, bit moen,
                      logic [AW-1:0] a, logic [W-1:0] d, string tag);
    bit s, e_rd, e_m;
    logic [W-1:0] e_d;
    en1_n = c1n; en2 = c2; en3_n = c3n; wr_n = wrn; den_n = denn;
    oe_n = oen; moe_n = moen; addr = a; din = d;
    @(posedge clk);
    #1;
    p_d  = m_mem[f_a];
    p_m  = f_cmp ? (m_mem[f_a] == m_hold) : 1'b1;
    p_rd = f_rd;
    s = !c1n && c2 && !c3n;
    if (!denn) m_hold = d;
    if (s && !wrn) m_mem[a] = m_hold;
    f_rd = s && wrn; f_cmp = s && wrn && !denn; f_a = a;
    @(negedge clk);
    e_rd = pipe_mode ? p_rd : f_rd;
    e_d  = pipe_mode ? p_d : m_mem[f_a];
    e_m  = pipe_mode ? p_m : (f_cmp ? (m_mem[f_a] == m_hold) : 1'b1);
    chk(tag, "dout_en", dout_en, !oen && e_rd);
    if (!oen && e_rd) chk(tag, "dout", dout, e_d);
    chk(tag, "match_en", match_en, !moen);
    if (!moen) chk(tag, "match", match, e_m);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [W-1:0] d, string tag);
    step(0, 1, 0, 0, 0, 1, 0, a, d, tag);
  endtask
  task automatic fill(logic [AW-1:0] a, logic [W-1:0] junk, string tag);
    step(0, 1, 0, 0, 1, 1, 0, a, junk, tag);
  endtask
  task automatic rd(logic [AW-1:0] a, logic [W-1:0] junk, string tag);
    step(0, 1, 0, 1, 1, 0, 0, a, junk, tag);
  endtask
  task automatic cmp(logic [AW-1:0] a, logic [W-1:0] t, string tag);
    step(0, 1, 0, 1, 0, 1, 0, a, t, tag);
  endtask
  task automatic idle(string tag);
    step(1, 1, 0, 1, 1, 0, 0, '0, '0, tag);
  endtask

  task automatic run_suite(string mtag);
    wr(1, 18'h2A5A5, "R3"); wr(2, 18'h3FFFF, "R3");
    wr(3, 18'h00001, "R3"); wr(4, 18'h20000, "R3");
    rd(1, 18'h11111, "R3"); rd(2, 18'h0, mtag); rd(4, 18'h0, "R10");
    cmp(2, 18'h3FFFF, "R5"); cmp(2, 18'h3FFFE, "R5");
    cmp(4, 18'h00000, "R5"); cmp(4, 18'h20000, "R5");
    cmp(3, 18'h15555, "R5");
    fill(3, 18'h0F0F0, "R4");
    rd(3, 18'h0, "R4");
    step(0, 1, 0, 1, 1, 1, 0, 5, 18'h33333, "R2");
    fill(6, 18'h0, "R2");
    rd(6, 18'h0, "R2");
    step(1, 1, 0, 0, 0, 1, 0, 1, 18'h00AAA, "R1");
    step(0, 0, 0, 0, 0, 1, 0, 1, 18'h00BBB, "R1");
    step(0, 1, 1, 0, 0, 1, 0, 1, 18'h00CCC, "R1");
    step(0, 0, 1, 1, 0, 0, 0, 1, 18'h0, "R6");
    rd(1, 18'h0, "R1");
    rd(2, 18'h0, "R6");
    step(0, 1, 0, 1, 1, 1, 0, 2, 18'h0, "R7");
    wr(7, 18'h12345, "R10");
    step(0, 1, 0, 0, 0, 0, 0, 8, 18'h23456, "R10");
    rd(7, 18'h0, mtag);
    idle("R6"); idle("R6");
  endtask

  initial begin
    for (int i = 0; i < D; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R6", "match after reset", match, 1);
    chk("R10", "dout_en after reset", dout_en, 0);
    rst_n = 1;
    @(negedge clk);
    pipe_mode = 0;
    run_suite("R8");
    pipe_mode = 1;
    idle("R9"); idle("R9");
    run_suite("R9");
    cmp(2, 18'h3FFFE, "R9");
    idle("R9");
    #3 oe_n = 0; moe_n = 1;
    #1 chk("R7", "match_en async off", match_en, 0);
    moe_n = 0;
    #1 chk("R7", "match_en async on", match_en, 1);
    pipe_mode = 0;
    rd(1, 18'h0, "R8");
    #3 oe_n = 1;
    #1 chk("R7", "dout_en async off", dout_en, 0);
    oe_n = 0;
    #1 chk("R7", "dout_en async on", dout_en, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule